// File: doc/BRIEF.md
# Remote Terminal Command Word Decoder

This block sits behind the bus receiver of a serial-bus remote terminal. It takes each 16-bit command word together with a one-cycle strobe. It decides whether the word is meant for this terminal, either through its own address or through the broadcast address. It then splits the word into direction, subaddress and count, and marks the command as a data transfer or a mode command. The terminal's own address comes from five hard-wired pins and one parity pin. These pins are sampled only while reset is held and are frozen from then on. An all-open pin set, which reads as all ones through the pull-ups, shows that the store has been released.

An option input selects the shorter response convention. In that convention, subaddress 31 becomes an ordinary data subaddress and only subaddress 0 introduces a mode command. An active-low illegalize input lets the subsystem reject the command it has just been told about. The decoded message error flag then goes high and the receive-data accept flag stays low. All outputs are registered. They change on the clock edge that samples the strobe.

Top module: `rt_cmd_decoder`

## Requirements
- R1: While `rst_ni` is low, all registered decode outputs are zero and the address and parity pins are captured. Once reset is released, later changes on those pins have no effect on `addr_err_o`, `store_rel_o` or on address matching.
- R2: Command word layout: bits 15..11 hold the target address, bit 10 is the direction (1 = terminal transmits, presented on `tx_o`), bits 9..5 hold the subaddress (`subaddr_o`), and bits 4..0 hold the word count or mode code (`mode_code_o`).
- R3: A strobed word is accepted when its address equals the captured address. A strobed word with any other non-broadcast address leaves every output unchanged and raises no `cmd_valid_o`.
- R4: Address 31 in a command is accepted as broadcast and drives `bcast_o` high. Any other accepted address drives `bcast_o` low.
- R5: With `fast_resp_i` low, subaddress 0 and subaddress 31 both mark a mode command (`mode_cmd_o` = 1).
- R6: With `fast_resp_i` high, only subaddress 0 marks a mode command, and subaddress 31 is decoded as a data transfer.
- R7: For a data transfer, `word_cnt_o` is the count field, with a count field of 0 giving 32. For a mode command, `word_cnt_o` is 0.
- R8: When `illegal_ni` is low in the strobe cycle of an accepted word, `msg_err_o` is 1 and `rx_accept_o` is 0. When it is high, `msg_err_o` is 0 and `rx_accept_o` is 1 exactly for a receive data transfer (direction 0, not a mode command).
- R9: `addr_err_o` is 1 when the six captured lines (address and parity) hold an even number of ones. While it is 1, no command is accepted.
- R10: `store_rel_o` is 1 exactly when all six captured lines are 1.
- R11: `cmd_valid_o` is a single-cycle pulse in the cycle after an accepted strobe. The decoded fields take their new values in that same cycle and hold them until the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; address pins captured while low |
| addr_pins_i | input | 5 | Hard-wired terminal address, bit 0 least significant |
| addr_par_i | input | 1 | Hard-wired address parity line (odd parity over six lines) |
| cmd_word_i | input | 16 | Received command word |
| cmd_stb_i | input | 1 | One-cycle strobe qualifying `cmd_word_i` |
| illegal_ni | input | 1 | Active-low illegalize, sampled with the strobe |
| fast_resp_i | input | 1 | Reduced-response convention: only subaddress 0 is a mode command |
| cmd_valid_o | output | 1 | Pulse: an accepted command was decoded |
| mode_cmd_o | output | 1 | Last accepted command is a mode command |
| bcast_o | output | 1 | Last accepted command was broadcast |
| tx_o | output | 1 | Direction of last accepted command (1 = transmit) |
| subaddr_o | output | 5 | Subaddress of last accepted command |
| mode_code_o | output | 5 | Raw count / mode code field |
| word_cnt_o | output | 6 | Data words expected (1..32), 0 for mode commands |
| msg_err_o | output | 1 | Last accepted command was illegalized |
| rx_accept_o | output | 1 | Received data of last command may be used |
| addr_err_o | output | 1 | Captured address fails odd parity |
| store_rel_o | output | 1 | All six captured address lines are high |

## Verification
The properties assume that `cmd_stb_i` and `illegal_ni` are held inactive during reset. They also assume that the illegalize level and the option input are valid in the strobe cycle itself, because the checks compare the registered flags with the inputs one cycle earlier. The bench drives all inputs on the falling clock edge and deasserts the strobe after exactly one cycle. It keeps the strobe low through every reset, and changes the address pins only around a reset. Sweeps cover every command address for several captured addresses. For correctly addressed words, they cover every subaddress and count in both directions under both conventions.

// File: rtl/rtcd_pkg.sv
package rtcd_pkg;
    localparam int AW      = 5;
    localparam int CW      = 16;
    localparam int SAW     = 5;
    localparam int WCW     = 5;
    localparam int CNTW    = WCW + 1;
    localparam int WC_LSB  = 0;
    localparam int SA_LSB  = WC_LSB + WCW;
    localparam int DIR_BIT = SA_LSB + SAW;
    localparam int AD_LSB  = DIR_BIT + 1;
    localparam logic [AW-1:0]   BCAST_ADDR = '1;
    localparam logic [CNTW-1:0] FULL_CNT   = CNTW'(1 << WCW);

    typedef struct packed {
        logic             hit;
        logic             bcast;
        logic             tx;
        logic             mode;
        logic [SAW-1:0]   sa;
        logic [WCW-1:0]   code;
        logic [CNTW-1:0]  cnt;
        logic             msg_err;
        logic             rx_ok;
    } cmd_dec_t;
endpackage

// File: rtl/rtcd_addr_latch.sv
module rtcd_addr_latch
    import rtcd_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] pins_i,
    input  logic          par_i,
    output logic [AW-1:0] own_o,
    output logic          err_o,
    output logic          rel_o
);
    logic [AW:0] lines_d, lines_q;

    always_comb begin
        lines_d = lines_q;
        if (!rst_ni) lines_d = {par_i, pins_i};
    end

    always_ff @(posedge clk_i) begin
        lines_q <= lines_d;
    end

    assign own_o = lines_q[AW-1:0];
    assign err_o = ~(^lines_q);
    assign rel_o = &lines_q;

    a_r1_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> $stable(own_o));
    a_r10_release_is_parity_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rel_o |-> err_o);
endmodule

// File: rtl/rtcd_classify.sv
module rtcd_classify
    import rtcd_pkg::*;
(
    input  logic [CW-1:0] cmd_i,
    input  logic [AW-1:0] own_i,
    input  logic          addr_err_i,
    input  logic          fast_i,
    input  logic          illegal_ni,
    output cmd_dec_t      dec_o
);
    logic [AW-1:0]  tgt;
    logic [SAW-1:0] sa;
    logic [WCW-1:0] wc;

    always_comb begin
        tgt = cmd_i[AD_LSB +: AW];
        sa  = cmd_i[SA_LSB +: SAW];
        wc  = cmd_i[WC_LSB +: WCW];

        dec_o.bcast   = (tgt == BCAST_ADDR);
        dec_o.hit     = !addr_err_i && ((tgt == own_i) || dec_o.bcast);
        dec_o.tx      = cmd_i[DIR_BIT];
        dec_o.sa      = sa;
        dec_o.code    = wc;
        dec_o.mode    = (sa == '0) || (!fast_i && (sa == '1));
        if (dec_o.mode)
            dec_o.cnt = '0;
        else if (wc == '0)
            dec_o.cnt = FULL_CNT;
        else
            dec_o.cnt = {1'b0, wc};
        dec_o.msg_err = !illegal_ni;
        dec_o.rx_ok   = illegal_ni && !dec_o.tx && !dec_o.mode;
    end
endmodule

// File: rtl/rt_cmd_decoder.sv
module rt_cmd_decoder
    import rtcd_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [AW-1:0]   addr_pins_i,
    input  logic            addr_par_i,
    input  logic [CW-1:0]   cmd_word_i,
    input  logic            cmd_stb_i,
    input  logic            illegal_ni,
    input  logic            fast_resp_i,
    output logic            cmd_valid_o,
    output logic            mode_cmd_o,
    output logic            bcast_o,
    output logic            tx_o,
    output logic [SAW-1:0]  subaddr_o,
    output logic [WCW-1:0]  mode_code_o,
    output logic [CNTW-1:0] word_cnt_o,
    output logic            msg_err_o,
    output logic            rx_accept_o,
    output logic            addr_err_o,
    output logic            store_rel_o
);
    logic [AW-1:0] own;
    cmd_dec_t      dec;
    cmd_dec_t      st_d, st_q;

    rtcd_addr_latch u_latch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pins_i (addr_pins_i),
        .par_i  (addr_par_i),
        .own_o  (own),
        .err_o  (addr_err_o),
        .rel_o  (store_rel_o)
    );

    rtcd_classify u_cls (
        .cmd_i      (cmd_word_i),
        .own_i      (own),
        .addr_err_i (addr_err_o),
        .fast_i     (fast_resp_i),
        .illegal_ni (illegal_ni),
        .dec_o      (dec)
    );

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        if (cmd_stb_i && dec.hit) st_d = dec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cmd_valid_o = st_q.hit;
    assign mode_cmd_o  = st_q.mode;
    assign bcast_o     = st_q.bcast;
    assign tx_o        = st_q.tx;
    assign subaddr_o   = st_q.sa;
    assign mode_code_o = st_q.code;
    assign word_cnt_o  = st_q.cnt;
    assign msg_err_o   = st_q.msg_err;
    assign rx_accept_o = st_q.rx_ok;

    a_r11_pulse_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o |-> $past(cmd_stb_i));
    a_r7_mode_no_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_cmd_o |-> (word_cnt_o == '0));
    a_r7_data_has_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_o && !mode_cmd_o) |-> (word_cnt_o != '0));
    a_r5_mode_subaddr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_cmd_o |-> ((subaddr_o == '0) || (subaddr_o == '1)));
    a_r6_fast_only_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_o && mode_cmd_o && $past(fast_resp_i)) |-> (subaddr_o == '0));
    a_r8_err_tracks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o |-> (msg_err_o == !$past(illegal_ni)));
    a_r8_err_blocks_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_err_o |-> !rx_accept_o);
    a_r9_bad_addr_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_err_o |-> !cmd_valid_o);
endmodule

// File: tb/tb_rt_cmd_decoder.sv
`timescale 1ns/1ps
module tb_rt_cmd_decoder;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [4:0]  addr_pins_i = '0;
    logic        addr_par_i = 1'b0;
    logic [15:0] cmd_word_i = '0;
    logic        cmd_stb_i = 1'b0;
    logic        illegal_ni = 1'b1;
    logic        fast_resp_i = 1'b0;
    logic        cmd_valid_o, mode_cmd_o, bcast_o, tx_o, msg_err_o, rx_accept_o;
    logic        addr_err_o, store_rel_o;
    logic [4:0]  subaddr_o, mode_code_o;
    logic [5:0]  word_cnt_o;

    int checks = 0;
    int fails  = 0;

    logic [4:0] own;
    logic       par;
    logic       e_err, e_rel, e_mode, e_bc, e_tx, e_me, e_rx;
    logic [4:0] e_sa, e_code;
    logic [5:0] e_cnt;

    always #4 clk_i = ~clk_i;

    rt_cmd_decoder dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_held(input string tag);
        chk({tag, " R2 subaddr"}, 32'(subaddr_o), 32'(e_sa));
        chk({tag, " R2 tx"}, 32'(tx_o), 32'(e_tx));
        chk({tag, " R2 code"}, 32'(mode_code_o), 32'(e_code));
        chk({tag, " R5/R6 mode"}, 32'(mode_cmd_o), 32'(e_mode));
        chk({tag, " R7 count"}, 32'(word_cnt_o), 32'(e_cnt));
        chk({tag, " R4 bcast"}, 32'(bcast_o), 32'(e_bc));
        chk({tag, " R8 msgerr"}, 32'(msg_err_o), 32'(e_me));
        chk({tag, " R8 rxaccept"}, 32'(rx_accept_o), 32'(e_rx));
    endtask

    task automatic do_reset(input logic [4:0] a, input logic p);
        @(negedge clk_i);
        own = a; par = p;
        addr_pins_i = a; addr_par_i = p; rst_ni = 1'b0;
        cmd_stb_i = 1'b0; illegal_ni = 1'b1;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        addr_pins_i = ~a; addr_par_i = ~p;
        e_err = ~(^{p, a}); e_rel = &{p, a};
        e_mode = 0; e_bc = 0; e_tx = 0; e_me = 0; e_rx = 0;
        e_sa = 0; e_code = 0; e_cnt = 0;
        @(negedge clk_i);
        chk("R1 reset valid", 32'(cmd_valid_o), 0);
        check_held("R1 reset");
        chk("R9 addr_err", 32'(addr_err_o), 32'(e_err));
        chk("R10 store_rel", 32'(store_rel_o), 32'(e_rel));
    endtask

    task automatic send(input logic [15:0] w, input logic fast, input logic ill_n);
        logic hit;
        @(negedge clk_i);
        chk("R11 pulse ended", 32'(cmd_valid_o), 0);
        cmd_word_i = w; cmd_stb_i = 1'b1; fast_resp_i = fast; illegal_ni = ill_n;
        @(negedge clk_i);
        cmd_stb_i = 1'b0; illegal_ni = 1'b1;
        hit = !e_err && (w[15:11] == own || w[15:11] == 5'd31);
        if (hit) begin
            e_bc   = (w[15:11] == 5'd31);
            e_tx   = w[10];
            e_sa   = w[9:5];
            e_code = w[4:0];
            e_mode = (w[9:5] == 0) || (!fast && w[9:5] == 5'd31);
            e_cnt  = e_mode ? 6'd0 : (w[4:0] == 0 ? 6'd32 : {1'b0, w[4:0]});
            e_me   = !ill_n;
            e_rx   = ill_n && !w[10] && !e_mode;
        end
        chk("R3/R11 valid", 32'(cmd_valid_o), 32'(hit));
        check_held(fast ? "R6" : "R5");
        chk("R1 addr_err frozen", 32'(addr_err_o), 32'(e_err));
    endtask

    task automatic addr_sweep();
        for (int a = 0; a < 32; a++) begin
            send({5'(a), 1'b0, 5'd1, 5'd3}, 1'b0, 1'b1);
            send({5'(a), 1'b1, 5'd31, 5'd0}, 1'b1, 1'b0);
        end
    endtask

    task automatic field_sweep();
        for (int f = 0; f < 2; f++)
            for (int t = 0; t < 2; t++)
                for (int s = 0; s < 32; s++)
                    for (int c = 0; c < 32; c++)
                        send({own, 1'(t), 5'(s), 5'(c)}, 1'(f), ((s + c) % 5) != 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        fails++;
        $display("FAIL R11 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset(5'd10, 1'b1); addr_sweep(); field_sweep();
        do_reset(5'd21, 1'b0); addr_sweep(); field_sweep();
        do_reset(5'd0,  1'b1); addr_sweep(); field_sweep();
        do_reset(5'd3,  1'b0); addr_sweep();   // R9 parity error
        do_reset(5'd31, 1'b1); addr_sweep();   // R10 store released
        chk("R10 store_rel high", 32'(store_rel_o), 1);
        @(negedge clk_i);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule